// File: doc/BRIEF.md
# Control Bus Register Responder

This block is the drive-side end of an asynchronous control and status bus. A controller places a unit number, a register code, a direction and, for writes, a 16-bit word with an odd parity bit on the bus, then raises demand. The responder brings demand into its own clock domain through a synchroniser and acts on its rising edge. If the unit number matches the drive's own, it stores the word or returns the addressed register. It then raises transfer and holds it until the controller has dropped demand.

The block holds sixteen general 16-bit registers. Register codes at or above sixteen are not backed by storage and set a sticky illegal-register flag. A write whose parity is not odd is thrown away and sets a sticky parity flag. An initialize input clears the registers and both flags. While the power-fail input is high, new demands and initialize are both ignored.

Top module: `ctlbus_reg_slave`

## Requirements
- R1: After reset, transfer and bus enable are low, both error flags are low and every register reads back as zero.
- R2: A write with odd parity (the XOR of the 16 data bits and the parity bit equals 1) to a legal code (0 to 15) for a matching unit stores the word, and a later read of that code returns it.
- R3: An access whose 3-bit unit select differs from the unit number input gets no transfer and changes no register.
- R4: Once raised, transfer stays high for as long as demand is held high, and falls only after demand has fallen.
- R5: During a read, the bus enable is high while transfer is high, and the returned word carries odd parity. The bus enable is low once transfer has fallen.
- R6: An access to a code from 16 to 31 completes the handshake and sets the illegal-register flag. A read of such a code returns zero with parity bit 1, and a write to it changes no register.
- R7: A write with even parity is discarded and sets the parity flag. The flag stays set until initialize clears it.
- R8: While power-fail is high, a demand gets no transfer and changes no register, and initialize clears nothing.
- R9: Initialize, with power-fail low, clears all sixteen registers and both error flags.
- R10: Direction, unit and register are taken at the synchronised demand edge. Changing the direction or data lines later in the same access has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drive clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_id | input | 3 | This drive's unit number |
| sel_unit | input | 3 | Unit select from the controller |
| sel_reg | input | 5 | Register code from the controller |
| dir_wr | input | 1 | High: controller writes; low: drive returns data |
| demand | input | 1 | Asynchronous demand from the controller |
| init | input | 1 | Asynchronous initialize from the controller |
| pwr_fail | input | 1 | Power-fail indication; blocks demand and initialize |
| bus_in | input | 16 | Control bus word from the controller |
| bus_in_par | input | 1 | Parity bit of bus_in (odd) |
| bus_out | output | 16 | Register word returned on a read |
| bus_out_par | output | 1 | Odd parity of bus_out |
| bus_oe | output | 1 | Enable for the drive's bus drivers |
| xfer | output | 1 | Transfer acknowledge |
| err_illegal | output | 1 | Sticky illegal-register flag |
| err_parity | output | 1 | Sticky write-parity flag |

## Verification
The hardest case to reach is an access whose lines change after the synchronised demand edge. The direction and data must differ between the cycle the responder samples them and the rest of the handshake. The bench gets there by waiting for transfer on a read and then flipping direction and data while demand is still held. A later read-back shows that no write took place. The power-fail cases are reached the same way: demand and initialize are pulsed with power-fail high, and the register contents are read back afterwards.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

    localparam int CTL_DATA_W = 16;
    localparam int REG_SEL_W  = 5;
    localparam int UNIT_W     = 3;
    localparam int NUM_REGS   = 16;
    localparam int RF_AW      = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SETUP = 2'd1,
        HS_ACK   = 2'd2
    } hs_state_t;

    // decoded request, evaluated at the demand edge
    typedef struct packed {
        logic             legal;
        logic             wr;
        logic             par_good;
        logic [RF_AW-1:0] addr;
    } ctl_req_t;

    function automatic logic odd_par_gen(input logic [CTL_DATA_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic logic odd_par_ok(input logic [CTL_DATA_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

    function automatic logic code_legal(input logic [REG_SEL_W-1:0] code);
        return 32'(code) < NUM_REGS;
    endfunction

endpackage

// File: rtl/ctlbus_sync.sv
module ctlbus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/ctlbus_regfile.sv
module ctlbus_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clr)
                mem[i] <= '0;
            else if (we && (32'(waddr) == i))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ctlbus_hs_fsm.sv
module ctlbus_hs_fsm
    import ctlbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dem_rise,
    input  logic dem_lvl,
    input  logic blocked,
    input  logic unit_match,
    input  logic wr_dir,
    output logic capture,
    output logic xfer,
    output logic drive_en
);
    hs_state_t state, state_nx;
    logic      is_read;

    assign capture = (state == HS_IDLE) && dem_rise && !blocked && unit_match;

    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE:  if (capture) state_nx = wr_dir ? HS_ACK : HS_SETUP;
            HS_SETUP: state_nx = HS_ACK;
            HS_ACK:   if (!dem_lvl) state_nx = HS_IDLE;
            default:  state_nx = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HS_IDLE;
            is_read <= 1'b0;
        end else begin
            state <= state_nx;
            if (capture) is_read <= !wr_dir;
        end
    end

    assign xfer     = (state == HS_ACK);
    assign drive_en = is_read && (state == HS_SETUP || state == HS_ACK);
endmodule

// File: rtl/ctlbus_reg_slave.sv
module ctlbus_reg_slave
    import ctlbus_pkg::*;
#(
    parameter int DATA_W      = CTL_DATA_W,
    parameter int SEL_W       = REG_SEL_W,
    parameter int UID_W       = UNIT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [UID_W-1:0]  unit_id,
    input  logic [UID_W-1:0]  sel_unit,
    input  logic [SEL_W-1:0]  sel_reg,
    input  logic              dir_wr,
    input  logic              demand,
    input  logic              init,
    input  logic              pwr_fail,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              bus_in_par,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_out_par,
    output logic              bus_oe,
    output logic              xfer,
    output logic              err_illegal,
    output logic              err_parity
);
    localparam int AW = RF_AW;

    logic [1:0]        sync_q;
    logic              dem_s, init_s, dem_prev, dem_rise, init_eff;
    logic              capture, rf_we, drive_en;
    logic [DATA_W-1:0] rf_rdata, rd_hold;
    ctl_req_t          req;

    ctlbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({init, demand}),
        .q   (sync_q)
    );

    assign dem_s    = sync_q[0];
    assign init_s   = sync_q[1];
    assign init_eff = init_s && !pwr_fail;

    always_ff @(posedge clk) begin
        if (rst) dem_prev <= 1'b0;
        else     dem_prev <= dem_s;
    end
    assign dem_rise = dem_s && !dem_prev;

    always_comb begin
        req.legal    = code_legal(sel_reg);
        req.wr       = dir_wr;
        req.par_good = odd_par_ok(bus_in, bus_in_par);
        req.addr     = sel_reg[AW-1:0];
    end

    ctlbus_hs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dem_rise   (dem_rise),
        .dem_lvl    (dem_s),
        .blocked    (pwr_fail),
        .unit_match (sel_unit == unit_id),
        .wr_dir     (req.wr),
        .capture    (capture),
        .xfer       (xfer),
        .drive_en   (drive_en)
    );

    assign rf_we = capture && req.wr && req.legal && req.par_good;

    ctlbus_regfile #(.DATA_W(DATA_W), .DEPTH(NUM_REGS), .AW(AW)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .clr   (init_eff),
        .we    (rf_we),
        .waddr (req.addr),
        .wdata (bus_in),
        .raddr (req.addr),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_illegal <= 1'b0;
            err_parity  <= 1'b0;
            rd_hold     <= '0;
        end else if (init_eff) begin
            err_illegal <= 1'b0;
            err_parity  <= 1'b0;
        end else if (capture) begin
            if (!req.legal)
                err_illegal <= 1'b1;
            else if (req.wr && !req.par_good)
                err_parity <= 1'b1;
            if (!req.wr)
                rd_hold <= req.legal ? rf_rdata : '0;
        end
    end

    assign bus_oe      = drive_en;
    assign bus_out     = drive_en ? rd_hold : '0;
    assign bus_out_par = drive_en ? odd_par_gen(rd_hold) : 1'b0;
endmodule

// File: rtl/ctlbus_reg_slave_chk.sv
module ctlbus_reg_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        demand,
    input logic        init,
    input logic        pwr_fail,
    input logic        xfer,
    input logic        bus_oe,
    input logic [15:0] bus_out,
    input logic        bus_out_par,
    input logic        err_illegal,
    input logic        err_parity
);
    // Depths below follow the two-stage synchroniser plus the edge that acts on it.

    // R4
    xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer) |-> !$past(demand, 3));

    // R5
    rd_parity_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (^{bus_out, bus_out_par}) == 1'b1);

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer) |-> !bus_oe);

    // R8
    pf_block_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> !$past(pwr_fail));

    // R7
    par_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_parity) |-> ($past(init, 3) && !$past(pwr_fail)));

    // R6
    ilr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_illegal) |-> ($past(init, 3) && !$past(pwr_fail)));
endmodule

bind ctlbus_reg_slave ctlbus_reg_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .demand      (demand),
    .init        (init),
    .pwr_fail    (pwr_fail),
    .xfer        (xfer),
    .bus_oe      (bus_oe),
    .bus_out     (bus_out),
    .bus_out_par (bus_out_par),
    .err_illegal (err_illegal),
    .err_parity  (err_parity)
);

// File: tb/tb_ctlbus_reg_slave.sv
`timescale 1ns/1ps
module tb_ctlbus_reg_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  unit_id = 3'd5;
    logic [2:0]  sel_unit = '0;
    logic [4:0]  sel_reg = '0;
    logic        dir_wr = 1'b0;
    logic        demand = 1'b0;
    logic        init = 1'b0;
    logic        pwr_fail = 1'b0;
    logic [15:0] bus_in = '0;
    logic        bus_in_par = 1'b0;
    logic [15:0] bus_out;
    logic        bus_out_par, bus_oe, xfer, err_illegal, err_parity;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] model [16];

    always #2.5 clk = ~clk;

    ctlbus_reg_slave dut (
        .clk(clk), .rst(rst), .unit_id(unit_id), .sel_unit(sel_unit),
        .sel_reg(sel_reg), .dir_wr(dir_wr), .demand(demand), .init(init),
        .pwr_fail(pwr_fail), .bus_in(bus_in), .bus_in_par(bus_in_par),
        .bus_out(bus_out), .bus_out_par(bus_out_par), .bus_oe(bus_oe),
        .xfer(xfer), .err_illegal(err_illegal), .err_parity(err_parity)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int c, input int salt);
        return 16'((c + 1) * 16'h1357 + salt * 16'h0F0F) ^ 16'h8421;
    endfunction

    // one complete handshake; flip changes direction and data after transfer
    task automatic access(input logic wr, input logic [2:0] unit, input logic [4:0] rc,
                          input logic [15:0] data, input logic par, input bit flip,
                          output bit got, output logic [15:0] rd, output logic rp, output logic oe);
        int n;
        @(negedge clk);
        sel_unit = unit; sel_reg = rc; dir_wr = wr; bus_in = data; bus_in_par = par;
        @(negedge clk);
        demand = 1'b1;
        got = 0; n = 0;
        while (!got && n < 12) begin
            @(negedge clk);
            n++;
            if (xfer) got = 1;
        end
        rd = bus_out; rp = bus_out_par; oe = bus_oe;
        if (got) begin
            if (flip) begin
                dir_wr = ~wr; bus_in = ~data; bus_in_par = ~par;
            end
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(xfer == 1'b1, "R4 xfer held while demand high", 32'(xfer), 32'd1);
            end
            demand = 1'b0;
            n = 0;
            while (xfer && n < 12) begin
                @(negedge clk);
                n++;
            end
            chk(n >= 2, "R4 xfer fell only after demand fell", 32'(n), 32'd2);
            chk(xfer == 1'b0, "R4 xfer released", 32'(xfer), 32'd0);
            chk(bus_oe == 1'b0, "R5 bus released after xfer", 32'(bus_oe), 32'd0);
        end else begin
            demand = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] unit, input logic [4:0] rc, input logic [15:0] d,
                          input bit bad, output bit got);
        logic [15:0] rd; logic rp, oe;
        access(1'b1, unit, rc, d, bad ? (^d) : ~(^d), 0, got, rd, rp, oe);
    endtask

    task automatic rd_reg(input logic [4:0] rc, input bit flip, output bit got,
                          output logic [15:0] rd, output logic rp, output logic oe);
        access(1'b0, 3'd5, rc, 16'hDEAD, 1'b0, flip, got, rd, rp, oe);
    endtask

    task automatic verify_all(input string req);
        bit got; logic [15:0] rd; logic rp, oe;
        for (int c = 0; c < 16; c++) begin
            rd_reg(5'(c), 0, got, rd, rp, oe);
            chk(got && oe, {req, " read completes with bus enabled"}, {30'd0, got, oe}, 32'd3);
            chk(rd == model[c], {req, " register content"}, 32'(rd), 32'(model[c]));
            chk(^{rd, rp} == 1'b1, "R5 odd parity on read", 32'({rd, rp}), 32'd1);
        end
    endtask

    task automatic pulse_init();
        @(negedge clk); init = 1'b1;
        repeat (4) @(negedge clk);
        init = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        bit got; logic [15:0] rd; logic rp, oe;
        for (int c = 0; c < 16; c++) model[c] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(xfer == 0 && bus_oe == 0, "R1 handshake idle", {30'd0, xfer, bus_oe}, 32'd0);
        chk(err_illegal == 0 && err_parity == 0, "R1 flags clear",
            {30'd0, err_illegal, err_parity}, 32'd0);
        verify_all("R1");

        // R2 write sweep over every legal code, read back
        for (int c = 0; c < 16; c++) begin
            wr_reg(3'd5, 5'(c), pat(c, 0), 0, got);
            chk(got, "R2 write acknowledged", 32'(got), 32'd1);
            model[c] = pat(c, 0);
        end
        verify_all("R2");
        chk(err_illegal == 0 && err_parity == 0, "R2 no flags on clean traffic",
            {30'd0, err_illegal, err_parity}, 32'd0);

        // R3 every other unit number is ignored
        for (int u = 0; u < 8; u++) begin
            if (u == 5) continue;
            wr_reg(3'(u), 5'(u), pat(u, 7), 0, got);
            chk(!got, "R3 no transfer for foreign unit", 32'(got), 32'd0);
        end
        verify_all("R3");

        // R6 illegal codes: writes and reads
        for (int c = 16; c < 32; c++) begin
            wr_reg(3'd5, 5'(c), pat(c, 3), 0, got);
            chk(got, "R6 illegal write still acknowledged", 32'(got), 32'd1);
            chk(err_illegal == 1, "R6 illegal flag set", 32'(err_illegal), 32'd1);
            rd_reg(5'(c), 0, got, rd, rp, oe);
            chk(got && rd == 16'h0 && rp == 1'b1, "R6 illegal read returns zero/par1",
                {15'd0, got, rd}, 32'h0001_0000);
        end
        chk(err_parity == 0, "R6 parity flag untouched", 32'(err_parity), 32'd0);
        verify_all("R6");

        // R9 initialize clears everything
        pulse_init();
        chk(err_illegal == 0 && err_parity == 0, "R9 flags cleared",
            {30'd0, err_illegal, err_parity}, 32'd0);
        for (int c = 0; c < 16; c++) model[c] = '0;
        verify_all("R9");

        // R7 bad parity write discarded, flag sticky
        for (int c = 0; c < 16; c++) begin
            wr_reg(3'd5, 5'(c), pat(c, 1), 0, got);
            model[c] = pat(c, 1);
        end
        wr_reg(3'd5, 5'd3, 16'h5A5A, 1, got);
        chk(got, "R7 bad-parity write acknowledged", 32'(got), 32'd1);
        chk(err_parity == 1, "R7 parity flag set", 32'(err_parity), 32'd1);
        chk(err_illegal == 0, "R7 illegal flag untouched", 32'(err_illegal), 32'd0);
        wr_reg(3'd5, 5'd4, 16'h0101, 0, got);
        model[4] = 16'h0101;
        chk(err_parity == 1, "R7 parity flag sticky", 32'(err_parity), 32'd1);
        verify_all("R7");

        // R10 lines changed after the demand edge have no effect
        rd_reg(5'd6, 1, got, rd, rp, oe);
        chk(got && rd == model[6], "R10 read returns sampled register", 32'(rd), 32'(model[6]));
        verify_all("R10");

        // R8 power-fail blocks demand and initialize
        @(negedge clk); pwr_fail = 1'b1;
        wr_reg(3'd5, 5'd7, 16'hFFFF, 0, got);
        chk(!got, "R8 no transfer under power-fail", 32'(got), 32'd0);
        pulse_init();
        chk(err_parity == 1, "R8 init ignored under power-fail", 32'(err_parity), 32'd1);
        @(negedge clk); pwr_fail = 1'b0;
        repeat (4) @(negedge clk);
        verify_all("R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule